// File: doc/BRIEF.md
# Partitioned Message Slot Allocator

This block hands out indices into a fixed pool of message buffer slots that incoming (receive) and outgoing (transmit) traffic share. Each slot carries one used flag. A requester raises a receive or a transmit request; in the same cycle the block answers with a grant, the chosen slot index, or a failure flag. The slot it grants becomes used at the next clock edge, so test and claim form one step. A separate free port returns a slot by index.

The reservation policy is the point of the block. Transmit requests may only take slots in the upper three quarters of the pool, so the lowest quarter always stays open for receive traffic. Transmit traffic can then fill the pool without blocking the responses it waits for. A free-slot count is kept beside the flags. A free of a slot that is already free raises an error pulse.

The pool size `POOL` is a parameter and must be a multiple of 4 (default 32). `QUART = POOL/4` is the first slot a transmit request may take.

Top module: `slot_pool_alloc`

## Requirements
- R1: After synchronous reset all slots are free, `free_cnt` equals `POOL`, and `grant`, `alloc_fail`, `tx_retry` and `free_err` are 0 while no request is present.
- R2: A receive request is granted, in the same cycle, the lowest-numbered free slot anywhere in the pool (index 0 to POOL-1).
- R3: A transmit request is granted the lowest-numbered free slot with index at least POOL/4, and is never granted a slot below POOL/4.
- R4: A granted slot is marked used at the clock edge that ends the grant cycle, so a later request is not granted it until it is freed.
- R5: When no eligible slot is free, the served request sees `alloc_fail`=1 and `grant`=0, and no used flag changes because of it.
- R6: A free (`free_vld`=1 with `free_idx`) clears that slot's used flag at the clock edge, whatever its prior state, and the slot becomes grantable again.
- R7: When a free and an allocation happen in the same cycle, the free is applied first, so the slot being freed may be granted in that cycle.
- R8: At most one allocation is served per cycle. When receive and transmit requests arrive together the receive request is served and `tx_retry`=1; otherwise `tx_retry`=0.
- R9: `free_err` is 1 in a cycle where `free_vld`=1 and the addressed slot is already free; the free-slot count does not change because of such a free.
- R10: `free_cnt` equals the number of slots whose used flag is clear, on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_req | input | 1 | Receive allocation request |
| tx_req | input | 1 | Transmit allocation request |
| free_vld | input | 1 | Release a slot this cycle |
| free_idx | input | $clog2(POOL) | Slot to release |
| grant | output | 1 | The served request got a slot |
| grant_idx | output | $clog2(POOL) | Index of the granted slot (0 when no grant) |
| alloc_fail | output | 1 | The served request found no eligible free slot |
| tx_retry | output | 1 | Transmit request lost to a receive request this cycle |
| free_err | output | 1 | Free addressed a slot that was already free |
| free_cnt | output | $clog2(POOL+1) | Number of free slots |

## Verification
Assertions check on every cycle that a transmit-only grant never lands below POOL/4, that a granted slot is used afterwards, that a failed request leaves the flags unchanged, that simultaneous requests raise the retry flag, and that the counter matches the flags. Only the bench scenarios can show that the grant is the lowest eligible slot, that a freed slot is grantable in the same cycle, and that the lowest quarter survives a transmit flood. They also show that a double free leaves the count alone.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;

    typedef enum logic {
        CAT_RX = 1'b0,
        CAT_TX = 1'b1
    } slot_cat_e;

    localparam int NUM_CAT = 2;

    // first slot a category may search from
    function automatic int cat_base(input slot_cat_e cat, input int pool);
        return (cat == CAT_TX) ? pool / 4 : 0;
    endfunction

endpackage

// File: rtl/slot_flags.sv
module slot_flags #(
    parameter int POOL  = 32,
    parameter int IDX_W = $clog2(POOL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    output logic [POOL-1:0]  used_q,
    output logic [POOL-1:0]  used_eff
);
    // view of the flags after this cycle's release
    always_comb begin
        used_eff = used_q;
        if (clr_en) used_eff[clr_idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q <= '0;
        end else begin
            used_q <= used_eff;
            if (set_en) used_q[set_idx] <= 1'b1;
        end
    end

    // R6: a released slot is free next cycle unless re-claimed
    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !used_q[$past(clr_idx)]);
endmodule

// File: rtl/slot_pick.sv
module slot_pick #(
    parameter int POOL  = 32,
    parameter int BASE  = 0,
    parameter int IDX_W = $clog2(POOL)
) (
    input  logic [POOL-1:0]  used_eff,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // scan downward so the lowest eligible free slot wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = POOL - 1; i >= BASE; i--) begin
            if (!used_eff[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/slot_counter.sv
module slot_counter #(
    parameter int POOL  = 32,
    parameter int CNT_W = $clog2(POOL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= CNT_W'(POOL);
        else if (inc && !dec)
            cnt <= cnt + CNT_W'(1);
        else if (dec && !inc)
            cnt <= cnt - CNT_W'(1);
    end

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(POOL));
endmodule

// File: rtl/slot_pool_alloc.sv
module slot_pool_alloc
    import slot_alloc_pkg::*;
#(
    parameter int POOL  = 32,
    parameter int IDX_W = $clog2(POOL),
    parameter int CNT_W = $clog2(POOL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_req,
    input  logic             tx_req,
    input  logic             free_vld,
    input  logic [IDX_W-1:0] free_idx,
    output logic             grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             alloc_fail,
    output logic             tx_retry,
    output logic             free_err,
    output logic [CNT_W-1:0] free_cnt
);
    localparam int QUART = POOL / 4;

    logic [POOL-1:0]  used_q, used_eff;
    logic [NUM_CAT-1:0] cat_found;
    logic [IDX_W-1:0] cat_idx [NUM_CAT];
    logic             serve_any;
    slot_cat_e        serve_cat;
    logic             rel_real;

    slot_flags #(.POOL(POOL), .IDX_W(IDX_W)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr_en  (free_vld),
        .clr_idx (free_idx),
        .set_en  (grant),
        .set_idx (grant_idx),
        .used_q  (used_q),
        .used_eff(used_eff)
    );

    for (genvar c = 0; c < NUM_CAT; c++) begin : g_pick
        slot_pick #(
            .POOL (POOL),
            .BASE (cat_base(slot_cat_e'(c), POOL)),
            .IDX_W(IDX_W)
        ) u_pick (
            .used_eff(used_eff),
            .found   (cat_found[c]),
            .idx     (cat_idx[c])
        );
    end

    // receive has priority; one allocation per cycle
    always_comb begin
        serve_any = rx_req || tx_req;
        serve_cat = rx_req ? CAT_RX : CAT_TX;
        grant     = serve_any && cat_found[serve_cat];
        grant_idx = grant ? cat_idx[serve_cat] : '0;
        alloc_fail = serve_any && !cat_found[serve_cat];
        tx_retry  = rx_req && tx_req;
        free_err  = free_vld && !used_q[free_idx];
        rel_real  = free_vld && used_q[free_idx];
    end

    slot_counter #(.POOL(POOL), .CNT_W(CNT_W)) u_cnt (
        .clk(clk),
        .rst(rst),
        .inc(rel_real),
        .dec(grant),
        .cnt(free_cnt)
    );

    p_tx_range_r3: assert property (@(posedge clk) disable iff (rst)
        (grant && tx_req && !rx_req) |-> grant_idx >= IDX_W'(QUART));

    p_claim_r4: assert property (@(posedge clk) disable iff (rst)
        grant |=> used_q[$past(grant_idx)]);

    p_fail_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (alloc_fail && !free_vld) |=> $stable(used_q));

    p_retry_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_req && tx_req) |-> tx_retry);

    p_count_match_r10: assert property (@(posedge clk) disable iff (rst)
        free_cnt == CNT_W'(POOL - $countones(used_q)));
endmodule

// File: tb/slot_pool_alloc_tb_top.sv
module slot_pool_alloc_tb_top;
    localparam int POOL  = 32;
    localparam int IDX_W = $clog2(POOL);
    localparam int CNT_W = $clog2(POOL + 1);
    localparam int QUART = POOL / 4;

    logic clk = 1'b0;
    logic rst;
    logic rx_req, tx_req, free_vld;
    logic [IDX_W-1:0] free_idx;
    logic grant, alloc_fail, tx_retry, free_err;
    logic [IDX_W-1:0] grant_idx;
    logic [CNT_W-1:0] free_cnt;

    int checks = 0;
    int errors = 0;
    bit ref_used [POOL];

    always #2 clk = ~clk;

    slot_pool_alloc #(.POOL(POOL)) dut_i (
        .clk(clk), .rst(rst), .rx_req(rx_req), .tx_req(tx_req),
        .free_vld(free_vld), .free_idx(free_idx), .grant(grant),
        .grant_idx(grant_idx), .alloc_fail(alloc_fail), .tx_retry(tx_retry),
        .free_err(free_err), .free_cnt(free_cnt)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one cycle: drive, compare against the reference model, advance it
    task automatic step(input string tag, input bit rx, input bit tx,
                        input bit fv, input int fi);
        bit eff [POOL];
        int base, pick, free_n;
        bit any, e_grant, e_fail, e_err;
        @(negedge clk);
        rx_req = rx; tx_req = tx; free_vld = fv; free_idx = IDX_W'(fi);
        #1;
        free_n = 0;
        foreach (ref_used[i]) begin
            eff[i] = ref_used[i];
            if (!ref_used[i]) free_n++;
        end
        e_err = fv && !ref_used[fi];
        if (fv) eff[fi] = 1'b0;
        any  = rx || tx;
        base = rx ? 0 : QUART;
        pick = -1;
        for (int i = POOL - 1; i >= base; i--) if (!eff[i]) pick = i;
        e_grant = any && pick >= 0;
        e_fail  = any && pick < 0;
        chk(tag, "grant", int'(grant), int'(e_grant));
        if (e_grant) chk(tag, "grant_idx", int'(grant_idx), pick);
        chk(tag, "alloc_fail", int'(alloc_fail), int'(e_fail));
        chk("R8", "tx_retry", int'(tx_retry), int'(rx && tx));
        chk("R9", "free_err", int'(free_err), int'(e_err));
        chk("R10", "free_cnt", int'(free_cnt), free_n);
        foreach (eff[i]) ref_used[i] = eff[i];
        if (e_grant) ref_used[pick] = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; rx_req = 0; tx_req = 0; free_vld = 0; free_idx = '0;
        foreach (ref_used[i]) ref_used[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1", "free_cnt", int'(free_cnt), POOL);
        chk("R1", "grant", int'(grant), 0);
        step("R1", 0, 0, 0, 0);
        // R2: receive takes lowest slots
        step("R2", 1, 0, 0, 0);
        step("R2", 1, 0, 0, 0);
        step("R2", 1, 0, 0, 0);
        // R3: transmit starts at POOL/4
        step("R3", 0, 1, 0, 0);
        step("R3", 0, 1, 0, 0);
        // R6: release slot 1, then R4/R2 it is re-granted to receive
        step("R6", 0, 0, 1, 1);
        step("R4", 1, 0, 0, 0);
        // R8: both requests, receive wins
        step("R8", 1, 1, 0, 0);
        // R9: double free of slot 5
        step("R9", 0, 0, 1, 5);
        // R3/R5: flood transmit until the upper part is exhausted
        for (int k = 0; k < POOL; k++) step("R3", 0, 1, 0, 0);
        step("R5", 0, 1, 0, 0);
        // lowest quarter still serves receive
        for (int k = 0; k < QUART; k++) step("R2", 1, 0, 0, 0);
        step("R5", 1, 0, 0, 0);
        // R7: free and claim the same slot in one cycle
        step("R7", 0, 1, 1, POOL - 1);
        step("R7", 1, 0, 1, 2);
        // R6: release everything, then receive restarts at 0
        for (int k = 0; k < POOL; k++) step("R6", 0, 0, 1, k);
        step("R2", 1, 0, 0, 0);
        step("R3", 0, 1, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule